// File: doc/BRIEF.md
# Message Object Transfer Engine

This block sits between a processor register window and a RAM of message objects, as used in a frame-oriented bus controller. Software fills a set of staging registers: acceptance mask, arbitration/identifier, per-object control and two data words. It then chooses a direction and a set of fields in a command-mask register, and writes an object number to the command-request register. The engine then performs one read-modify-write of that object. It either loads the chosen fields from the staging registers into the object, or copies them from the object into the staging registers. While it works, a busy flag is visible to software.

A read transfer can also clear the object's pending-interrupt flag and its new-data flag. A write transfer can raise the object's transmit request without touching the rest of its control word. Four packed vectors follow the valid, transmit-request, new-data and pending-interrupt flags of every object, so software can see them without a transfer. A stall input lets the protocol engine keep the RAM read port for itself. While it is high, the fetch step of a pending transfer waits. After reset the engine clears every object before it accepts commands.

Top module: `msgram_xfer`

## Requirements
- R1: After reset the engine is busy for OBJS (32) cycles while it writes zero into every object. The four summary vectors read zero. Afterwards every field of every object reads back as zero.
- R2: A write of an object number from 1 to OBJS into bits 5:0 of the command-request register (address 0) starts a transfer. Busy (bit 15 of a command-request read) is set from the next cycle. With no stall, busy clears two cycles after the write, well inside the six-cycle limit.
- R3: While eng_stall is high, a started transfer waits in its fetch step with busy held set. It completes two cycles after eng_stall falls.
- R4: A command-request write while busy is ignored. So is a write with object number 0 or above OBJS. The last accepted object number stays in bits 5:0 of the command-request read.
- R5: A write transfer has command-mask bit 7 set. It copies into the object only the selected fields: bit 6 mask, bit 5 arbitration, bit 4 control, bit 1 data A, bit 0 data B. Unselected object fields keep their value.
- R6: A read transfer has command-mask bit 7 clear. It copies the fields selected by bits 6, 5, 4, 1 and 0 from the object into the staging registers. Unselected staging registers keep their value.
- R7: A read transfer with command-mask bit 3 clears the object's pending-interrupt bit (control bit 13). With bit 2 it clears the object's new-data bit (control bit 15). The staging control register receives the value from before the clear.
- R8: A write transfer with command-mask bit 2 sets the object's transmit-request bit (control bit 8). This holds whatever the staging control value and whether or not bit 4 is set.
- R9: Bit n-1 of sum_valid, sum_txrq, sum_newdat and sum_intpnd follows object n's arbitration bit 31, control bit 8, control bit 15 and control bit 13. A vector changes only in the cycle after a transfer's write-back.
- R10: Writes to the command-mask and staging registers are ignored while busy.
- R11: reg_rdata is registered. It shows, one cycle later, the register addressed by reg_addr. The addresses are: 0 command request, 1 command mask, 2/3 mask low/high, 4/5 arbitration low/high, 6 control, 7/8 data A low/high, 9/10 data B low/high. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data of reg_addr |
| eng_stall | input | 1 | Protocol engine holds the RAM; fetch waits |
| sum_valid | output | OBJS | Per-object valid flags |
| sum_txrq | output | OBJS | Per-object transmit-request flags |
| sum_newdat | output | OBJS | Per-object new-data flags |
| sum_intpnd | output | OBJS | Per-object pending-interrupt flags |

## Verification
Transfers run with a full field selection and then with sparse masks (arbitration plus data A, data B alone, control with the clear bits). Filling the staging registers with a marker value first separates copied fields from fields left alone. Write transfers that carry only the transmit-request bit show that the side effect acts without a control copy. Read transfers with the clear bits show the old value reaching the staging register while the summary flags drop. Command writes that come mid-transfer, object numbers 0 and 33, a held stall, and objects 1 and 32 check the start rule, the stall and both ends of the summary vectors.

// File: rtl/msgram_pkg.sv
package msgram_pkg;

  typedef struct packed {
    logic [31:0] msk;
    logic [31:0] arb;
    logic [15:0] ctl;
    logic [31:0] da;
    logic [31:0] db;
  } obj_rec_t;

  localparam int REC_W = $bits(obj_rec_t);

  // command-mask bit positions
  localparam int CM_DIR   = 7;
  localparam int CM_MSK   = 6;
  localparam int CM_ARB   = 5;
  localparam int CM_CTL   = 4;
  localparam int CM_CLRIP = 3;
  localparam int CM_TXND  = 2;
  localparam int CM_DA    = 1;
  localparam int CM_DB    = 0;

  // control and arbitration flag positions
  localparam int CT_NEWDAT = 15;
  localparam int CT_INTPND = 13;
  localparam int CT_TXRQ   = 8;
  localparam int AR_VALID  = 31;

  // register word addresses
  localparam logic [3:0] A_CMDREQ = 4'd0;
  localparam logic [3:0] A_CMDMSK = 4'd1;
  localparam logic [3:0] A_MSK_LO = 4'd2;
  localparam logic [3:0] A_MSK_HI = 4'd3;
  localparam logic [3:0] A_ARB_LO = 4'd4;
  localparam logic [3:0] A_ARB_HI = 4'd5;
  localparam logic [3:0] A_CTL    = 4'd6;
  localparam logic [3:0] A_DA_LO  = 4'd7;
  localparam logic [3:0] A_DA_HI  = 4'd8;
  localparam logic [3:0] A_DB_LO  = 4'd9;
  localparam logic [3:0] A_DB_HI  = 4'd10;

  typedef enum logic [1:0] {ST_INIT, ST_IDLE, ST_FETCH, ST_MERGE} xfer_st_t;

endpackage

// File: rtl/msgram_obj_ram.sv
module msgram_obj_ram #(
  parameter int DEPTH = 32,
  parameter int W     = 144,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/msgram_merge.sv
module msgram_merge
  import msgram_pkg::*;
(
  input  logic [7:0] cmask,
  input  obj_rec_t   ram_in,
  input  obj_rec_t   ifc_in,
  output obj_rec_t   ram_out,
  output obj_rec_t   ifc_out
);

  always_comb begin
    ram_out = ram_in;
    ifc_out = ifc_in;
    if (cmask[CM_DIR]) begin
      // staging -> object
      if (cmask[CM_MSK]) ram_out.msk = ifc_in.msk;
      if (cmask[CM_ARB]) ram_out.arb = ifc_in.arb;
      if (cmask[CM_CTL]) ram_out.ctl = ifc_in.ctl;
      if (cmask[CM_DA])  ram_out.da  = ifc_in.da;
      if (cmask[CM_DB])  ram_out.db  = ifc_in.db;
      if (cmask[CM_TXND]) ram_out.ctl[CT_TXRQ] = 1'b1;
    end else begin
      // object -> staging, flags cleared in the object afterwards
      if (cmask[CM_MSK]) ifc_out.msk = ram_in.msk;
      if (cmask[CM_ARB]) ifc_out.arb = ram_in.arb;
      if (cmask[CM_CTL]) ifc_out.ctl = ram_in.ctl;
      if (cmask[CM_DA])  ifc_out.da  = ram_in.da;
      if (cmask[CM_DB])  ifc_out.db  = ram_in.db;
      if (cmask[CM_CLRIP]) ram_out.ctl[CT_INTPND] = 1'b0;
      if (cmask[CM_TXND])  ram_out.ctl[CT_NEWDAT] = 1'b0;
    end
  end

endmodule

// File: rtl/msgram_summary.sv
module msgram_summary
  import msgram_pkg::*;
#(
  parameter int OBJS = 32,
  localparam int AW  = $clog2(OBJS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd,
  input  logic [AW-1:0]   idx,
  input  obj_rec_t        rec,
  output logic [OBJS-1:0] sum_valid,
  output logic [OBJS-1:0] sum_txrq,
  output logic [OBJS-1:0] sum_newdat,
  output logic [OBJS-1:0] sum_intpnd
);

  for (genvar i = 0; i < OBJS; i++) begin : g_obj
    always_ff @(posedge clk) begin
      if (rst) begin
        sum_valid[i]  <= 1'b0;
        sum_txrq[i]   <= 1'b0;
        sum_newdat[i] <= 1'b0;
        sum_intpnd[i] <= 1'b0;
      end else if (upd && idx == AW'(i)) begin
        sum_valid[i]  <= rec.arb[AR_VALID];
        sum_txrq[i]   <= rec.ctl[CT_TXRQ];
        sum_newdat[i] <= rec.ctl[CT_NEWDAT];
        sum_intpnd[i] <= rec.ctl[CT_INTPND];
      end
    end
  end

endmodule

// File: rtl/msgram_xfer.sv
module msgram_xfer
  import msgram_pkg::*;
#(
  parameter int OBJS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_wr_en,
  input  logic [3:0]      reg_addr,
  input  logic [15:0]     reg_wdata,
  output logic [15:0]     reg_rdata,
  input  logic            eng_stall,
  output logic [OBJS-1:0] sum_valid,
  output logic [OBJS-1:0] sum_txrq,
  output logic [OBJS-1:0] sum_newdat,
  output logic [OBJS-1:0] sum_intpnd
);

  localparam int AW = $clog2(OBJS);
  localparam int NW = $clog2(OBJS + 1);

  xfer_st_t        state;
  logic [AW-1:0]   init_ctr;
  logic [NW-1:0]   obj_num;
  logic [AW-1:0]   obj_idx;
  logic [7:0]      cmask;
  obj_rec_t        ifc;
  obj_rec_t        ram_q;
  obj_rec_t        ram_new;
  obj_rec_t        ifc_new;
  logic            busy;
  logic            in_init;
  logic            ram_we;
  logic            ram_re;
  logic [AW-1:0]   ram_waddr;
  logic [REC_W-1:0] ram_wdata;
  logic [REC_W-1:0] ram_rdata;
  logic [NW-1:0]   req_num;
  logic            req_ok;

  assign busy    = (state != ST_IDLE);
  assign in_init = (state == ST_INIT);
  assign obj_idx = AW'(obj_num - NW'(1));
  assign req_num = reg_wdata[NW-1:0];
  assign req_ok  = reg_wr_en && (reg_addr == A_CMDREQ) &&
                   (req_num != '0) && (req_num <= NW'(OBJS));

  // RAM port control
  assign ram_we    = in_init || (state == ST_MERGE);
  assign ram_waddr = in_init ? init_ctr : obj_idx;
  assign ram_wdata = in_init ? '0 : ram_new;
  assign ram_re    = (state == ST_FETCH) && !eng_stall;
  assign ram_q     = ram_rdata;

  msgram_obj_ram #(.DEPTH(OBJS), .W(REC_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (obj_idx),
    .rdata (ram_rdata)
  );

  msgram_merge u_merge (
    .cmask   (cmask),
    .ram_in  (ram_q),
    .ifc_in  (ifc),
    .ram_out (ram_new),
    .ifc_out (ifc_new)
  );

  msgram_summary #(.OBJS(OBJS)) u_sum (
    .clk        (clk),
    .rst        (rst),
    .upd        (state == ST_MERGE),
    .idx        (obj_idx),
    .rec        (ram_new),
    .sum_valid  (sum_valid),
    .sum_txrq   (sum_txrq),
    .sum_newdat (sum_newdat),
    .sum_intpnd (sum_intpnd)
  );

  // transfer sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_INIT;
      init_ctr <= '0;
      obj_num  <= '0;
    end else begin
      case (state)
        ST_INIT: begin
          init_ctr <= init_ctr + AW'(1);
          if (init_ctr == AW'(OBJS - 1)) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (req_ok) begin
            obj_num <= req_num;
            state   <= ST_FETCH;
          end
        end
        ST_FETCH: if (!eng_stall) state <= ST_MERGE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // staging registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ifc   <= '0;
      cmask <= '0;
    end else if (state == ST_MERGE) begin
      ifc <= ifc_new;
    end else if (reg_wr_en && !busy) begin
      case (reg_addr)
        A_CMDMSK: cmask          <= reg_wdata[7:0];
        A_MSK_LO: ifc.msk[15:0]  <= reg_wdata;
        A_MSK_HI: ifc.msk[31:16] <= reg_wdata;
        A_ARB_LO: ifc.arb[15:0]  <= reg_wdata;
        A_ARB_HI: ifc.arb[31:16] <= reg_wdata;
        A_CTL:    ifc.ctl        <= reg_wdata;
        A_DA_LO:  ifc.da[15:0]   <= reg_wdata;
        A_DA_HI:  ifc.da[31:16]  <= reg_wdata;
        A_DB_LO:  ifc.db[15:0]   <= reg_wdata;
        A_DB_HI:  ifc.db[31:16]  <= reg_wdata;
        default: ;
      endcase
    end
  end

  // registered read mux
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        A_CMDREQ: reg_rdata <= {busy, {(15 - NW){1'b0}}, obj_num};
        A_CMDMSK: reg_rdata <= {8'h00, cmask};
        A_MSK_LO: reg_rdata <= ifc.msk[15:0];
        A_MSK_HI: reg_rdata <= ifc.msk[31:16];
        A_ARB_LO: reg_rdata <= ifc.arb[15:0];
        A_ARB_HI: reg_rdata <= ifc.arb[31:16];
        A_CTL:    reg_rdata <= ifc.ctl;
        A_DA_LO:  reg_rdata <= ifc.da[15:0];
        A_DA_HI:  reg_rdata <= ifc.da[31:16];
        A_DB_LO:  reg_rdata <= ifc.db[15:0];
        A_DB_HI:  reg_rdata <= ifc.db[31:16];
        default:  reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/msgram_xfer_chk.sv
module msgram_xfer_chk #(
  parameter int OBJS = 32,
  localparam int NW  = $clog2(OBJS + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            in_init,
  input logic            eng_stall,
  input logic            ram_re,
  input logic            ram_we,
  input logic            reg_wr_en,
  input logic [3:0]      reg_addr,
  input logic [15:0]     reg_wdata,
  input logic [NW-1:0]   obj_num,
  input logic [OBJS-1:0] sum_valid,
  input logic [OBJS-1:0] sum_txrq
);

  logic [3:0] run_cnt;

  // unstalled busy cycles of the current transfer
  always_ff @(posedge clk) begin
    if (rst || !busy || in_init) run_cnt <= '0;
    else if (!eng_stall && run_cnt != 4'hF) run_cnt <= run_cnt + 4'd1;
  end

  // R2: a legal command write while idle starts a transfer
  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && reg_wr_en && reg_addr == 4'd0 &&
     reg_wdata[NW-1:0] != '0 && reg_wdata[NW-1:0] <= NW'(OBJS)) |=> busy);

  // R2: finishes inside six unstalled cycles
  assert_deadline_R2: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= 4'd6);

  // R3: no RAM fetch while the protocol engine stalls
  assert_stall_R3: assert property (@(posedge clk) disable iff (rst)
    eng_stall |-> !ram_re);

  // R4: command writes during busy do not retarget
  assert_ignore_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr_en && reg_addr == 4'd0) |=> $stable(obj_num));

  // R9: summaries move only after a write-back
  assert_summary_R9: assert property (@(posedge clk) disable iff (rst)
    !ram_we |=> ($stable(sum_txrq) && $stable(sum_valid)));

endmodule

bind msgram_xfer msgram_xfer_chk #(.OBJS(OBJS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .in_init   (in_init),
  .eng_stall (eng_stall),
  .ram_re    (ram_re),
  .ram_we    (ram_we),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .obj_num   (obj_num),
  .sum_valid (sum_valid),
  .sum_txrq  (sum_txrq)
);

// File: tb/msgram_xfer_test.sv
`timescale 1ns/1ps
module msgram_xfer_test;

  localparam int OBJS = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        eng_stall = 1'b0;
  logic [31:0] sum_valid, sum_txrq, sum_newdat, sum_intpnd;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  msgram_xfer #(.OBJS(OBJS)) uut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_stall(eng_stall),
    .sum_valid(sum_valid), .sum_txrq(sum_txrq),
    .sum_newdat(sum_newdat), .sum_intpnd(sum_intpnd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_msk [OBJS];
  logic [31:0] m_arb [OBJS];
  logic [15:0] m_ctl [OBJS];
  logic [31:0] m_da  [OBJS];
  logic [31:0] m_db  [OBJS];
  logic [31:0] i_msk, i_arb, i_da, i_db;
  logic [15:0] i_ctl;
  logic [7:0]  i_cm;
  int          init_left, ph, cur;
  logic [5:0]  last_obj;
  logic [15:0] e_rdata;
  logic [31:0] e_val, e_txr, e_nd, e_ip;

  function automatic logic [15:0] model_read(input logic [3:0] a, input logic bsy);
    case (a)
      4'd0:  return {bsy, 9'd0, last_obj};
      4'd1:  return {8'd0, i_cm};
      4'd2:  return i_msk[15:0];
      4'd3:  return i_msk[31:16];
      4'd4:  return i_arb[15:0];
      4'd5:  return i_arb[31:16];
      4'd6:  return i_ctl;
      4'd7:  return i_da[15:0];
      4'd8:  return i_da[31:16];
      4'd9:  return i_db[15:0];
      4'd10: return i_db[31:16];
      default: return 16'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      init_left = OBJS; ph = 0; cur = 0; last_obj = 0; e_rdata = 0;
      e_val = 0; e_txr = 0; e_nd = 0; e_ip = 0;
      i_msk = 0; i_arb = 0; i_ctl = 0; i_da = 0; i_db = 0; i_cm = 0;
      for (int k = 0; k < OBJS; k++) begin
        m_msk[k] = 0; m_arb[k] = 0; m_ctl[k] = 0; m_da[k] = 0; m_db[k] = 0;
      end
    end else begin
      logic bsy;
      bsy = (init_left > 0) || (ph != 0);
      e_rdata = model_read(reg_addr, bsy);
      if (init_left > 0) init_left--;
      else if (ph == 1) begin
        if (!eng_stall) ph = 2;
      end else if (ph == 2) begin
        if (i_cm[7]) begin
          if (i_cm[6]) m_msk[cur] = i_msk;
          if (i_cm[5]) m_arb[cur] = i_arb;
          if (i_cm[4]) m_ctl[cur] = i_ctl;
          if (i_cm[1]) m_da[cur]  = i_da;
          if (i_cm[0]) m_db[cur]  = i_db;
          if (i_cm[2]) m_ctl[cur][8] = 1'b1;
        end else begin
          if (i_cm[6]) i_msk = m_msk[cur];
          if (i_cm[5]) i_arb = m_arb[cur];
          if (i_cm[4]) i_ctl = m_ctl[cur];
          if (i_cm[1]) i_da  = m_da[cur];
          if (i_cm[0]) i_db  = m_db[cur];
          if (i_cm[3]) m_ctl[cur][13] = 1'b0;
          if (i_cm[2]) m_ctl[cur][15] = 1'b0;
        end
        e_val[cur] = m_arb[cur][31];
        e_txr[cur] = m_ctl[cur][8];
        e_nd[cur]  = m_ctl[cur][15];
        e_ip[cur]  = m_ctl[cur][13];
        ph = 0;
      end else if (reg_wr_en && reg_addr == 4'd0 &&
                   reg_wdata[5:0] >= 1 && reg_wdata[5:0] <= OBJS) begin
        cur = int'(reg_wdata[5:0]) - 1;
        last_obj = reg_wdata[5:0];
        ph = 1;
      end
      if (reg_wr_en && !bsy) begin
        case (reg_addr)
          4'd1:  i_cm = reg_wdata[7:0];
          4'd2:  i_msk[15:0] = reg_wdata;
          4'd3:  i_msk[31:16] = reg_wdata;
          4'd4:  i_arb[15:0] = reg_wdata;
          4'd5:  i_arb[31:16] = reg_wdata;
          4'd6:  i_ctl = reg_wdata;
          4'd7:  i_da[15:0] = reg_wdata;
          4'd8:  i_da[31:16] = reg_wdata;
          4'd9:  i_db[15:0] = reg_wdata;
          4'd10: i_db[31:16] = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R11 model rdata", {16'd0, reg_rdata}, {16'd0, e_rdata});
      chk("R9 model sum_valid", sum_valid, e_val);
      chk("R9 model sum_txrq", sum_txrq, e_txr);
      chk("R9 model sum_newdat", sum_newdat, e_nd);
      chk("R9 model sum_intpnd", sum_intpnd, e_ip);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [15:0] exp);
    reg_addr = a;
    @(negedge clk);
    chk(req, {16'd0, reg_rdata}, {16'd0, exp});
  endtask

  task automatic set_all(input logic [15:0] v);
    for (int a = 2; a <= 10; a++) wr(4'(a), v);
  endtask

  task automatic xfer(input logic [5:0] obj, input logic [7:0] cm);
    wr(4'd1, {8'd0, cm});
    wr(4'd0, {10'd0, obj});
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(500000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset sum_valid", sum_valid, 32'd0);
    chk("R1 reset sum_txrq", sum_txrq, 32'd0);
    rst = 1'b0;
    rd("R1 busy during clear", 4'd0, 16'h8000);
    repeat (34) @(negedge clk);
    rd("R1 idle after clear", 4'd0, 16'h0000);

    // R1: a cleared object reads back zero
    set_all(16'hAAAA);
    xfer(6'd20, 8'h73);
    rd("R1 cleared msk", 4'd2, 16'h0000);
    rd("R1 cleared arb", 4'd5, 16'h0000);
    rd("R1 cleared db", 4'd10, 16'h0000);

    // R5: full write of object 5, with R2 busy timing
    wr(4'd2, 16'h0F0F); wr(4'd3, 16'h8001);
    wr(4'd4, 16'h1234); wr(4'd5, 16'hA456);
    wr(4'd6, 16'hA088);
    wr(4'd7, 16'h1111); wr(4'd8, 16'h2222);
    wr(4'd9, 16'h3333); wr(4'd10, 16'h4444);
    wr(4'd1, 16'h00F3);
    wr(4'd0, 16'd5);
    rd("R2 busy first cycle", 4'd0, 16'h8005);
    rd("R2 busy second cycle", 4'd0, 16'h8005);
    rd("R2 busy released", 4'd0, 16'h0005);
    chk("R9 valid obj5", sum_valid, 32'h0000_0010);
    chk("R9 newdat obj5", sum_newdat, 32'h0000_0010);
    chk("R9 intpnd obj5", sum_intpnd, 32'h0000_0010);

    // R6: full read back
    set_all(16'h0000);
    xfer(6'd5, 8'h73);
    rd("R6 msk lo", 4'd2, 16'h0F0F);
    rd("R6 arb hi", 4'd5, 16'hA456);
    rd("R6 ctl", 4'd6, 16'hA088);
    rd("R6 db hi", 4'd10, 16'h4444);

    // R6: partial read keeps unselected staging registers
    set_all(16'hAAAA);
    xfer(6'd5, 8'h22);
    rd("R6 arb lo copied", 4'd4, 16'h1234);
    rd("R6 da hi copied", 4'd8, 16'h2222);
    rd("R6 msk lo kept", 4'd2, 16'hAAAA);
    rd("R6 ctl kept", 4'd6, 16'hAAAA);
    rd("R6 db lo kept", 4'd9, 16'hAAAA);

    // R7: read with flag clears
    xfer(6'd5, 8'h1C);
    rd("R7 ctl pre-clear value", 4'd6, 16'hA088);
    chk("R7 intpnd cleared", sum_intpnd, 32'd0);
    chk("R7 newdat cleared", sum_newdat, 32'd0);
    xfer(6'd5, 8'h10);
    rd("R7 object ctl after clear", 4'd6, 16'h0088);

    // R8: transmit request without a control copy
    xfer(6'd7, 8'h84);
    chk("R8 txrq obj7", sum_txrq, 32'h0000_0040);
    xfer(6'd7, 8'h73);
    rd("R8 obj7 ctl", 4'd6, 16'h0100);
    rd("R5 obj7 arb untouched", 4'd5, 16'h0000);

    // R5: partial write keeps unselected object fields
    wr(4'd9, 16'h5555); wr(4'd10, 16'h6666); wr(4'd7, 16'h7777);
    xfer(6'd5, 8'h81);
    set_all(16'h0000);
    xfer(6'd5, 8'h73);
    rd("R5 db lo written", 4'd9, 16'h5555);
    rd("R5 db hi written", 4'd10, 16'h6666);
    rd("R5 da lo kept", 4'd7, 16'h1111);

    // R4 and R10: writes during busy are dropped
    wr(4'd2, 16'h0101);
    wr(4'd1, 16'h0084);
    wr(4'd0, 16'd9);
    wr(4'd0, 16'd10);
    wr(4'd2, 16'h5A5A);
    repeat (2) @(negedge clk);
    chk("R4 obj9 served", sum_txrq[8], 1'b1);
    chk("R4 obj10 ignored", sum_txrq[9], 1'b0);
    rd("R4 object number kept", 4'd0, 16'h0009);
    rd("R10 staging write dropped", 4'd2, 16'h0101);

    // R4: out-of-range object numbers
    wr(4'd0, 16'd0);
    rd("R4 object 0 ignored", 4'd0, 16'h0009);
    wr(4'd0, 16'd33);
    rd("R4 object 33 ignored", 4'd0, 16'h0009);

    // R3: stall holds the fetch; object 32 is the top boundary
    eng_stall = 1'b1;
    wr(4'd0, 16'd32);
    repeat (5) rd("R3 busy while stalled", 4'd0, 16'h8020);
    chk("R3 no update while stalled", sum_txrq[31], 1'b0);
    eng_stall = 1'b0;
    repeat (2) @(negedge clk);
    rd("R3 done after stall", 4'd0, 16'h0020);
    chk("R9 txrq obj32", sum_txrq[31], 1'b1);

    // R9: object 1 is the bottom boundary
    xfer(6'd1, 8'h84);
    chk("R9 txrq obj1", sum_txrq[0], 1'b1);

    // R11: registered read of a staging register
    wr(4'd8, 16'hBEEF);
    rd("R11 read latency", 4'd8, 16'hBEEF);
    rd("R11 unmapped address", 4'd14, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule